// File: doc/BRIEF.md
# Run-Time Configurable Block Cipher Round Engine

This block runs the rounds of an AES-style cipher over one 128-bit block, either forward (encrypt) or backward (decrypt). It works one round per clock. Three things that a standard AES-128 core fixes at build time are inputs here. The number of rounds is an input. The byte-substitution table is a writable RAM. The column-mixing step multiplies in GF(2^8) modulo a polynomial given at run time. Per-round keys come from an external store. The engine drives a round index, and the store returns the 128-bit key for that index in the same cycle.

The table contents and the expanded keys are loaded by the surrounding system before an operation begins. A caller presents the block, the mode, the round count and the field polynomial together with a one-cycle start. The engine then returns the result with a one-cycle done pulse. The result stays on the output until the next accepted start. A start that carries an illegal round count raises an error flag and does nothing else.

Top module: `aes_flex_core`

## Requirements
- R1: State byte i (i = 0..15) sits at din/dout bits [127-8i -: 8], with byte i in row i mod 4 and column i div 4. Encryption with N rounds computes s = din ^ K0. Each of rounds 1..N-1 then applies table substitution, the row shift, column mixing and XOR with Kr. The last round applies substitution, the row shift and XOR with KN, with no mixing. The row shift takes output (row r, column c) from input (r, (c+r) mod 4).
- R2: Decryption computes s = din ^ KN. Each of rounds r = 1..N-1 applies the inverse row shift (output (r,c) from input (r,(c-r) mod 4)), then substitution through the inverse table, then XOR with K(N-r), then inverse mixing. The last round does the inverse shift, the inverse substitution and XOR with K0.
- R3: An accepted start is sampled on a clock edge E0. The result and a high done appear after edge EN, where N is the round count, so there is one round per cycle.
- R4: A start with a round count outside 3..11 (4-bit field) sets err after that edge, produces no done and leaves dout unchanged. The next accepted start clears err.
- R5: done is high for exactly one cycle. dout holds its value from then until the next accepted start.
- R6: A start that arrives while an operation is in progress is ignored, and the running operation completes with its original inputs.
- R7: There are two 256x8 substitution tables, written through sb_we/sb_addr/sb_wdata. sb_inv=0 selects the forward table and sb_inv=1 the inverse. Encryption reads the forward table and decryption reads the inverse.
- R8: Column mixing multiplies a column [a0..a3] by the circulant row {02,03,01,01} forward or {0e,0b,0d,09} inverse, where output byte r = c0*a[r] ^ c1*a[r+1] ^ c2*a[r+2] ^ c3*a[r+3] (indices mod 4). Products are taken modulo x^8 + field_poly, and field_poly is captured at start.
- R9: rk_idx is the index of the key used at the next edge. Encryption uses 0,1,..,N and decryption uses N,N-1,..,0. During the start cycle rk_idx follows the decrypt and rounds inputs.
- R10: After reset dout is zero and done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (one cycle) |
| decrypt | input | 1 | 0 encrypt, 1 decrypt; sampled at start |
| rounds | input | 4 | Round count N; legal 3..11 |
| field_poly | input | 8 | Low 8 bits of the field polynomial (x^8 implied) |
| din | input | 128 | Input block |
| sb_we | input | 1 | Substitution table write enable |
| sb_inv | input | 1 | Write target: 0 forward table, 1 inverse table |
| sb_addr | input | 8 | Table write address |
| sb_wdata | input | 8 | Table write data |
| rk_idx | output | 4 | Round-key index requested |
| rk_data | input | 128 | Round key for rk_idx, same cycle |
| dout | output | 128 | Result block |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start rejected for an illegal round count |

## Verification
A fault in the state register or in one substitution lane stays hidden until done. Because mixing spreads every byte across its column and the row shift spreads columns, a single wrong byte then shows up as most of the 16 output bytes differing from the arithmetic model. An error in the step counter or the captured round count shows a cycle earlier or later, as a done pulse off by one, and as a wrong rk_idx in the very cycle it occurs. A mode or polynomial capture fault leaves latency correct but breaks both the known-answer result and the encrypt-then-decrypt round trip.

// File: rtl/aes_flex_pkg.sv
package aes_flex_pkg;
  localparam int BYTE_W    = 8;
  localparam int ROWS      = 4;
  localparam int COLS      = 4;
  localparam int LANES     = ROWS * COLS;
  localparam int BLOCK_W   = LANES * BYTE_W;
  localparam int COL_W     = ROWS * BYTE_W;
  localparam int TAB_DEPTH = 1 << BYTE_W;

  typedef enum logic {PH_IDLE, PH_RUN} phase_t;

  // multiply by x modulo x^8 + poly
  function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] a,
                                                input logic [BYTE_W-1:0] poly);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? poly : '0);
  endfunction

  // multiply by a 4-bit constant through a doubling chain
  function automatic logic [BYTE_W-1:0] gf_scale(input logic [BYTE_W-1:0] a,
                                                  input logic [3:0]        c,
                                                  input logic [BYTE_W-1:0] poly);
    logic [BYTE_W-1:0] a2, a4, a8;
    a2 = gf_dbl(a, poly);
    a4 = gf_dbl(a2, poly);
    a8 = gf_dbl(a4, poly);
    return (c[0] ? a : '0) ^ (c[1] ? a2 : '0) ^ (c[2] ? a4 : '0) ^ (c[3] ? a8 : '0);
  endfunction
endpackage

// File: rtl/aes_flex_subst.sv
module aes_flex_subst import aes_flex_pkg::*; (
  input  logic               clk,
  input  logic               wr_en,
  input  logic               wr_inv,
  input  logic [BYTE_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic               rd_inv,
  input  logic [BLOCK_W-1:0] blk_in,
  output logic [BLOCK_W-1:0] blk_out
);
  logic [BYTE_W-1:0] fwd_tab [TAB_DEPTH];
  logic [BYTE_W-1:0] inv_tab [TAB_DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_inv) inv_tab[wr_addr] <= wr_data;
      else        fwd_tab[wr_addr] <= wr_data;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BYTE_W-1:0] lane_idx;
    assign lane_idx = blk_in[BLOCK_W-1-BYTE_W*i -: BYTE_W];
    assign blk_out[BLOCK_W-1-BYTE_W*i -: BYTE_W] = rd_inv ? inv_tab[lane_idx]
                                                          : fwd_tab[lane_idx];
  end
endmodule

// File: rtl/aes_flex_rowshift.sv
module aes_flex_rowshift import aes_flex_pkg::*; (
  input  logic               inverse,
  input  logic [BLOCK_W-1:0] blk_in,
  output logic [BLOCK_W-1:0] blk_out
);
  logic [BLOCK_W-1:0] fwd_blk, inv_blk;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int DST   = COLS * c + r;
      localparam int SRC_F = COLS * ((c + r) % COLS) + r;
      localparam int SRC_I = COLS * ((c + COLS - r) % COLS) + r;
      assign fwd_blk[BLOCK_W-1-BYTE_W*DST -: BYTE_W] = blk_in[BLOCK_W-1-BYTE_W*SRC_F -: BYTE_W];
      assign inv_blk[BLOCK_W-1-BYTE_W*DST -: BYTE_W] = blk_in[BLOCK_W-1-BYTE_W*SRC_I -: BYTE_W];
    end
  end

  assign blk_out = inverse ? inv_blk : fwd_blk;
endmodule

// File: rtl/aes_flex_colmix.sv
module aes_flex_colmix import aes_flex_pkg::*; (
  input  logic              inverse,
  input  logic [BYTE_W-1:0] poly,
  input  logic [COL_W-1:0]  col_in,
  output logic [COL_W-1:0]  col_out
);
  logic [BYTE_W-1:0] a [ROWS];
  logic [COL_W-1:0]  fwd_col, inv_col;

  for (genvar r = 0; r < ROWS; r++) begin : g_byte
    localparam int R1 = (r + 1) % ROWS;
    localparam int R2 = (r + 2) % ROWS;
    localparam int R3 = (r + 3) % ROWS;
    assign a[r] = col_in[COL_W-1-BYTE_W*r -: BYTE_W];
    assign fwd_col[COL_W-1-BYTE_W*r -: BYTE_W] =
      gf_scale(a[r], 4'h2, poly) ^ gf_scale(a[R1], 4'h3, poly) ^ a[R2] ^ a[R3];
    assign inv_col[COL_W-1-BYTE_W*r -: BYTE_W] =
      gf_scale(a[r], 4'he, poly) ^ gf_scale(a[R1], 4'hb, poly) ^
      gf_scale(a[R2], 4'hd, poly) ^ gf_scale(a[R3], 4'h9, poly);
  end

  assign col_out = inverse ? inv_col : fwd_col;
endmodule

// File: rtl/aes_flex_core.sv
module aes_flex_core import aes_flex_pkg::*; #(
  parameter  int MIN_ROUNDS = 3,
  parameter  int MAX_ROUNDS = 11,
  localparam int RND_W      = $clog2(MAX_ROUNDS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               decrypt,
  input  logic [RND_W-1:0]   rounds,
  input  logic [BYTE_W-1:0]  field_poly,
  input  logic [BLOCK_W-1:0] din,
  input  logic               sb_we,
  input  logic               sb_inv,
  input  logic [BYTE_W-1:0]  sb_addr,
  input  logic [BYTE_W-1:0]  sb_wdata,
  output logic [RND_W-1:0]   rk_idx,
  input  logic [BLOCK_W-1:0] rk_data,
  output logic [BLOCK_W-1:0] dout,
  output logic               done,
  output logic               err
);
  phase_t             phase_q;
  logic [BLOCK_W-1:0] state_q;
  logic [RND_W-1:0]   step_q, nr_q;
  logic               dec_q, done_q, err_q;
  logic [BYTE_W-1:0]  poly_q;

  // named events for the checker
  logic busy, rounds_ok, accept, reject, last_step;
  assign busy      = (phase_q == PH_RUN);
  assign rounds_ok = (rounds >= RND_W'(MIN_ROUNDS)) && (rounds <= RND_W'(MAX_ROUNDS));
  assign accept    = !busy && start && rounds_ok;
  assign reject    = !busy && start && !rounds_ok;
  assign last_step = busy && (step_q == nr_q);

  always_comb begin
    if (busy) rk_idx = dec_q ? (nr_q - step_q) : step_q;
    else      rk_idx = decrypt ? rounds : '0;
  end

  // round datapath
  logic [BLOCK_W-1:0] subbed, shifted, keyed, mix_in, mixed, round_out;

  aes_flex_subst u_subst (
    .clk     (clk),
    .wr_en   (sb_we),
    .wr_inv  (sb_inv),
    .wr_addr (sb_addr),
    .wr_data (sb_wdata),
    .rd_inv  (dec_q),
    .blk_in  (state_q),
    .blk_out (subbed)
  );

  // substitution is bytewise, so it commutes with the row shift in both modes
  aes_flex_rowshift u_shift (
    .inverse (dec_q),
    .blk_in  (subbed),
    .blk_out (shifted)
  );

  assign keyed  = shifted ^ rk_data;
  assign mix_in = dec_q ? keyed : shifted;

  for (genvar c = 0; c < COLS; c++) begin : g_mix
    aes_flex_colmix u_col (
      .inverse (dec_q),
      .poly    (poly_q),
      .col_in  (mix_in[BLOCK_W-1-COL_W*c -: COL_W]),
      .col_out (mixed[BLOCK_W-1-COL_W*c -: COL_W])
    );
  end

  always_comb begin
    if (last_step)  round_out = keyed;
    else if (dec_q) round_out = mixed;
    else            round_out = mixed ^ rk_data;
  end

  // control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      state_q <= '0;
      step_q  <= '0;
      nr_q    <= '0;
      dec_q   <= 1'b0;
      poly_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        phase_q <= PH_RUN;
        state_q <= din ^ rk_data;
        step_q  <= RND_W'(1);
        nr_q    <= rounds;
        dec_q   <= decrypt;
        poly_q  <= field_poly;
        err_q   <= 1'b0;
      end else if (reject) begin
        err_q <= 1'b1;
      end else if (busy) begin
        state_q <= round_out;
        if (last_step) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end else begin
          step_q <= step_q + RND_W'(1);
        end
      end
    end
  end

  assign dout = state_q;
  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/aes_flex_core_chk.sv
module aes_flex_core_chk #(
  parameter int RND_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             err,
  input logic [127:0]     dout,
  input logic             busy,
  input logic             accept,
  input logic             reject,
  input logic             last_step,
  input logic [RND_W-1:0] step,
  input logic [RND_W-1:0] nr,
  input logic [RND_W-1:0] rk_idx
);
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> $stable(dout));

  a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r3_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> (busy && step == RND_W'($past(step) + 1'b1)));

  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> (nr == $past(nr)));

  a_r4_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (err && !busy && !done));

  a_r4_err_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !done);

  a_r9_key_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rk_idx <= nr));
endmodule

bind aes_flex_core aes_flex_core_chk #(.RND_W(RND_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .err       (err),
  .dout      (dout),
  .busy      (busy),
  .accept    (accept),
  .reject    (reject),
  .last_step (last_step),
  .step      (step_q),
  .nr        (nr_q),
  .rk_idx    (rk_idx)
);

// File: tb/aes_flex_core_test.sv
`timescale 1ns/1ps
module aes_flex_core_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, decrypt = 1'b0;
  logic [3:0]   rounds = 4'd0;
  logic [7:0]   field_poly = 8'h1b;
  logic [127:0] din = '0;
  logic         sb_we = 1'b0, sb_inv = 1'b0;
  logic [7:0]   sb_addr = '0, sb_wdata = '0;
  logic [3:0]   rk_idx;
  logic [127:0] rk_data;
  logic [127:0] dout;
  logic         done, err;

  int n_cmp = 0, n_bad = 0;
  logic [7:0]   std_f [256];
  logic [7:0]   cur_f [256];
  logic [7:0]   cur_i [256];
  logic [127:0] rkeys [16];

  always #2.5 clk = ~clk;
  always_comb rk_data = rkeys[rk_idx];

  aes_flex_core uut (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------- arithmetic model ----------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b,
                                       input logic [7:0] poly);
    logic [7:0] p = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= a;
      a = a[7] ? ((a << 1) ^ poly) : (a << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] bt(input logic [127:0] s, input int i);
    return s[127-8*i -: 8];
  endfunction

  function automatic logic [127:0] m_sub(input logic [127:0] s, input bit inv);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = inv ? cur_i[bt(s, i)] : cur_f[bt(s, i)];
    return o;
  endfunction

  function automatic logic [127:0] m_shift(input logic [127:0] s, input bit inv);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = bt(s, 4*((inv ? (c + 4 - r) : (c + r)) % 4) + r);
    return o;
  endfunction

  function automatic logic [127:0] m_mix(input logic [127:0] s, input bit inv,
                                         input logic [7:0] poly);
    logic [7:0] cf [4];
    logic [127:0] o;
    if (inv) cf = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
    else     cf = '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] acc = 8'h00;
        for (int j = 0; j < 4; j++) acc ^= m_mul(cf[(j - r + 4) % 4], bt(s, 4*c+j), poly);
        o[127-8*(4*c+r) -: 8] = acc;
      end
    return o;
  endfunction

  function automatic logic [127:0] m_enc(input logic [127:0] p, input int n,
                                         input logic [7:0] poly);
    logic [127:0] s = p ^ rkeys[0];
    for (int r = 1; r <= n; r++) begin
      s = m_shift(m_sub(s, 1'b0), 1'b0);
      if (r < n) s = m_mix(s, 1'b0, poly);
      s ^= rkeys[r];
    end
    return s;
  endfunction

  function automatic logic [127:0] m_dec(input logic [127:0] c, input int n,
                                         input logic [7:0] poly);
    logic [127:0] s = c ^ rkeys[n];
    for (int r = 1; r <= n; r++) begin
      s = m_sub(m_shift(s, 1'b1), 1'b1) ^ rkeys[n-r];
      if (r < n) s = m_mix(s, 1'b1, poly);
    end
    return s;
  endfunction

  // standard table from field inverse and affine map
  function automatic void build_std();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] v = 8'h01, y;
      for (int k = 0; k < 254; k++) v = m_mul(v, 8'(x), 8'h1b);
      y = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
      std_f[x] = y;
    end
  endfunction

  function automatic void expand_key(input logic [127:0] key);
    logic [31:0] w [48];
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 48; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {std_f[t[31:24]], std_f[t[23:16]], std_f[t[15:8]], std_f[t[7:0]]} ^ {rc, 24'h0};
        rc = m_mul(rc, 8'h02, 8'h1b);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int k = 0; k < 12; k++) rkeys[k] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
    for (int k = 12; k < 16; k++) rkeys[k] = '0;
  endfunction

  task automatic load_tables();
    for (int t = 0; t < 2; t++)
      for (int a = 0; a < 256; a++) begin
        @(negedge clk);
        sb_we = 1'b1; sb_inv = t[0]; sb_addr = 8'(a);
        sb_wdata = t[0] ? cur_i[a] : cur_f[a];
      end
    @(negedge clk);
    sb_we = 1'b0;
  endtask

  task automatic do_op(input bit dec, input int n, input logic [7:0] poly,
                       input logic [127:0] data, output logic [127:0] res,
                       output int lat, output bit seq_ok);
    seq_ok = 1'b1;
    @(negedge clk);
    start = 1'b1; decrypt = dec; rounds = 4'(n); field_poly = poly; din = data;
    #1;
    if (rk_idx != (dec ? 4'(n) : 4'd0)) seq_ok = 1'b0;
    @(negedge clk);
    start = 1'b0; lat = 0;
    while (!done && lat < 40) begin
      if (rk_idx != (dec ? 4'(n - 1 - lat) : 4'(lat + 1))) seq_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    res = dout;
  endtask

  task automatic op_check(input bit dec, input int n, input logic [7:0] poly,
                          input logic [127:0] data, input logic [127:0] exp,
                          input string req, output logic [127:0] res);
    int lat;
    bit seq_ok;
    do_op(dec, n, poly, data, res, lat, seq_ok);
    chk(res == exp, req, res, exp);
    chk(lat == n, "R3 latency", 128'(lat), 128'(n));
    chk(seq_ok, "R9 key index sequence", 128'(seq_ok), 128'(1));
    @(negedge clk);
    chk(!done && dout == res, "R5 single done / held output", {127'(dout), done}, {127'(res), 1'b0});
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL R3 watchdog expired actual=%h expected=%h", 128'(0), 128'(1));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] res, ct, held, pats [3];
    logic [127:0] kat_pt = 128'h3243f6a8885a308d313198a2e0370734;
    logic [127:0] kat_ct = 128'h3925841d02dc09fbdc118597196a0b32;
    int lat;
    bit seq_ok;
    pats = '{128'h00112233445566778899aabbccddeeff, 128'h0, 128'hffffffff00000000a5a5a5a55a5a5a5a};

    build_std();
    for (int i = 0; i < 256; i++) begin cur_f[i] = std_f[i]; cur_i[std_f[i]] = 8'(i); end
    expand_key(128'h2b7e151628aed2a6abf7158809cf4f3c);

    repeat (3) @(negedge clk);
    chk(dout == '0 && !done && !err, "R10 reset state", {dout[127:2], done, err}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dout == '0 && !done && !err, "R10 after release", {dout[127:2], done, err}, '0);

    load_tables();

    // R1 R7 R8 known answer, then R2 back
    op_check(1'b0, 10, 8'h1b, kat_pt, kat_ct, "R1 known-answer encrypt", res);
    op_check(1'b1, 10, 8'h1b, kat_ct, kat_pt, "R2 known-answer decrypt", res);

    // sweep all legal round counts, both modes, standard tables
    for (int n = 3; n <= 11; n++)
      for (int p = 0; p < 3; p++) begin
        op_check(1'b0, n, 8'h1b, pats[p], m_enc(pats[p], n, 8'h1b), "R1 encrypt sweep", ct);
        op_check(1'b1, n, 8'h1b, ct, pats[p], "R2 decrypt round trip", res);
      end

    // R7 R8 custom tables and polynomial
    for (int i = 0; i < 256; i++) begin
      cur_f[i] = 8'(i * 29 + 101);
      cur_i[8'(i * 29 + 101)] = 8'(i);
    end
    load_tables();
    for (int k = 0; k < 3; k++) begin
      int n = 3 + 4 * k;
      op_check(1'b0, n, 8'h1d, pats[k], m_enc(pats[k], n, 8'h1d), "R8 encrypt custom poly/table", res);
      op_check(1'b1, n, 8'h1d, pats[k], m_dec(pats[k], n, 8'h1d), "R7 decrypt inverse table", res);
    end
    op_check(1'b0, 5, 8'h1b, pats[0], m_enc(pats[0], 5, 8'h1b), "R8 round trip custom table", ct);
    op_check(1'b1, 5, 8'h1b, ct, pats[0], "R7 custom table round trip", res);

    // R4 illegal round counts
    held = dout;
    for (int b = 0; b < 4; b++) begin
      int bad_n = (b == 0) ? 0 : (b == 1) ? 2 : (b == 2) ? 12 : 15;
      bit saw_done = 1'b0;
      @(negedge clk);
      start = 1'b1; rounds = 4'(bad_n); din = pats[1]; decrypt = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk(err == 1'b1, "R4 err on illegal count", 128'(err), 128'(1));
      repeat (14) begin @(negedge clk); if (done) saw_done = 1'b1; end
      chk(!saw_done && dout == held, "R4 no operation", {127'(dout), saw_done}, {127'(held), 1'b0});
    end
    op_check(1'b0, 4, 8'h1b, pats[2], m_enc(pats[2], 4, 8'h1b), "R4 valid start after reject", res);
    chk(err == 1'b0, "R4 err cleared", 128'(err), 128'(0));

    // R6 start during an operation
    @(negedge clk);
    start = 1'b1; decrypt = 1'b0; rounds = 4'd11; field_poly = 8'h1b; din = pats[0];
    @(negedge clk);
    start = 1'b0; lat = 0;
    repeat (3) begin @(negedge clk); lat++; end
    start = 1'b1; decrypt = 1'b1; rounds = 4'd3; din = pats[2];
    @(negedge clk);
    start = 1'b0; lat++;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    chk(dout == m_enc(pats[0], 11, 8'h1b), "R6 busy start ignored", dout, m_enc(pats[0], 11, 8'h1b));
    chk(lat == 11, "R6 latency kept", 128'(lat), 128'(11));
    chk(err == 1'b0, "R6 no error", 128'(err), 128'(0));

    // R5 output held over a longer idle gap
    held = dout;
    repeat (10) @(negedge clk);
    chk(dout == held && !done, "R5 idle hold", dout, held);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule